// File: doc/BRIEF.md
# Strobe-Framed Dual-Lane I/Q Deserializer

This block sits behind the receive pins of a source-synchronous serial sample link. Four signals arrive with the data clock: a strobe and two serial lanes, one carrying I bits and one carrying Q bits. Each bit slot holds one I bit and one Q bit, and both lanes shift in lockstep. The strobe is high in the slot that holds the first bit of a sample. The block uses that slot as the word boundary, gathers the configured number of bits on both lanes, and presents the two rebuilt words together with a single-cycle valid pulse.

Three run-time inputs control the format. One selects a 16-bit or 12-bit sample. One selects whether the first bit is the most or the least significant. One selects whether bits are captured on the rising clock edge only, or on both edges. In double-rate capture, a rising-edge slot is followed by a falling-edge slot. The falling-edge bit is held until the next rising edge, and the two slots are then processed in arrival order within one cycle. A strobe that arrives in the middle of a word drops the partial word and sets a sticky error flag. The strobe bit then starts a fresh word.

Top module: `iq_lane_deser`

## Requirements
- R1: While rst_ni is low and right after its release, valid_o and frame_err_o are 0 and i_word_o and q_word_o are all zeros.
- R2: After reset, every slot before the first strobe is ignored, and valid_o stays low.
- R3: With width16_i=1 and lsb_first_i=0, the strobe slot supplies bit 15 and later slots supply bits 14 down to 0. In single-rate mode, valid_o goes high in the cycle after the rising edge that samples the last bit.
- R4: With width16_i=0, a word is 12 slots long and bit 11 comes first in MSB-first order. Bits 15:12 of both output words are 0.
- R5: With lsb_first_i=1, the strobe slot supplies bit 0 and later slots fill upward, to bit 15 or bit 11.
- R6: The I lane and the Q lane are assembled from the same slots. Both words update on the same valid_o pulse.
- R7: With ddr_i=1, a slot is sampled on every rising edge and every falling edge, and the strobe may fall in either kind of slot. A falling-edge slot takes effect at the next rising edge. valid_o rises one cycle after the rising edge that follows, or is, the edge sampling the last bit.
- R8: valid_o is high for exactly one cycle per completed word. Between pulses, i_word_o and q_word_o hold their last values.
- R9: A strobe that arrives after at least one bit of an unfinished word drops that partial word with no valid pulse. It sets frame_err_o one cycle after the edge that processes the strobe, and the strobe bit becomes the first bit of a new word.
- R10: After a word completes, slots without a strobe are ignored until the next strobe.
- R11: Once set, frame_err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock that comes with the lanes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width16_i | input | 1 | 1 selects 16-bit samples, 0 selects 12-bit samples |
| lsb_first_i | input | 1 | 1 selects least significant bit first, 0 most significant first |
| ddr_i | input | 1 | 1 captures on both clock edges, 0 on rising edges only |
| strobe_i | input | 1 | High in the slot holding a sample's first bit |
| i_lane_i | input | 1 | Serial I data lane |
| q_lane_i | input | 1 | Serial Q data lane |
| valid_o | output | 1 | One-cycle pulse when a new I/Q pair is presented |
| i_word_o | output | 16 | Assembled I word, zero-extended in 12-bit mode |
| q_word_o | output | 16 | Assembled Q word, zero-extended in 12-bit mode |
| frame_err_o | output | 1 | Sticky flag for a strobe that arrived mid-word |

## Verification
Every slot the bench drives is tagged with the rising edge that processes it. In single-rate mode that is the next rising edge. In double-rate mode it is the same next rising edge for both a rising-edge slot and a falling-edge slot. valid_o, the two words and any new frame error are therefore all due one cycle after that edge. The bench model files each expected pair under that cycle number. A monitor samples on the falling edge, away from where inputs change, and compares against the exact cycle number. A pulse that is early, late, missing or unexpected fails. The error flag is compared against its due cycle on every cycle. The word outputs are compared against the last pair in every cycle without a pulse.

// File: rtl/iq_deser_pkg.sv
package iq_deser_pkg;

  typedef enum logic {
    ORD_MSB = 1'b0,
    ORD_LSB = 1'b1
  } bit_order_e;

  typedef enum logic {
    CAP_SDR = 1'b0,
    CAP_DDR = 1'b1
  } cap_mode_e;

  typedef struct packed {
    logic stb;
    logic di;
    logic dq;
  } lane_slot_t;

  // slots handled per rising edge in double-rate mode
  localparam int unsigned SLOTS_PER_CYCLE = 2;

endpackage

// File: rtl/iq_ddr_capture.sv
module iq_ddr_capture
  import iq_deser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lane_slot_t slot_i,
  output lane_slot_t fall_o
);

  lane_slot_t fall_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= slot_i;
  end

  assign fall_o = fall_q;

endmodule

// File: rtl/iq_slot_step.sv
module iq_slot_step
  import iq_deser_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5
) (
  input  logic          en_i,
  input  logic          lsb_i,
  input  logic [CW-1:0] nbits_i,
  input  lane_slot_t    slot_i,
  input  logic          aligned_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-1:0]  acc_i_i,
  input  logic [W-1:0]  acc_q_i,
  output logic          aligned_o,
  output logic [CW-1:0] cnt_o,
  output logic [W-1:0]  acc_i_o,
  output logic [W-1:0]  acc_q_o,
  output logic          done_o,
  output logic          ferr_o
);

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] acc, input logic b,
                                            input logic lsb, input logic [CW-1:0] nb);
    logic [W-1:0] r;
    if (lsb) begin
      r = acc >> 1;
      for (int k = 0; k < W; k++) begin
        if (k == int'(nb) - 1) r[k] = b;
      end
    end else begin
      r = {acc[W-2:0], b};
    end
    return r;
  endfunction

  always_comb begin
    aligned_o = aligned_i;
    cnt_o     = cnt_i;
    acc_i_o   = acc_i_i;
    acc_q_o   = acc_q_i;
    done_o    = 1'b0;
    ferr_o    = 1'b0;
    if (en_i) begin
      if (slot_i.stb) begin
        ferr_o    = aligned_i && (cnt_i != '0);
        aligned_o = 1'b1;
        acc_i_o   = push_bit('0, slot_i.di, lsb_i, nbits_i);
        acc_q_o   = push_bit('0, slot_i.dq, lsb_i, nbits_i);
        cnt_o     = CW'(1);
      end else if (aligned_i && (cnt_i != '0)) begin
        acc_i_o   = push_bit(acc_i_i, slot_i.di, lsb_i, nbits_i);
        acc_q_o   = push_bit(acc_q_i, slot_i.dq, lsb_i, nbits_i);
        cnt_o     = cnt_i + CW'(1);
      end
      if ((cnt_o != '0) && (cnt_o >= nbits_i)) begin
        done_o = 1'b1;
        cnt_o  = '0;
      end
    end
  end

endmodule

// File: rtl/iq_deser_core.sv
module iq_deser_core
  import iq_deser_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ddr_i,
  input  logic          lsb_i,
  input  logic [CW-1:0] nbits_i,
  input  lane_slot_t    live_i,
  input  lane_slot_t    fall_i,
  output logic          done_o,
  output logic          ferr_o,
  output logic [W-1:0]  word_i_o,
  output logic [W-1:0]  word_q_o
);

  localparam int unsigned NS = SLOTS_PER_CYCLE;

  logic          aligned_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  acc_i_q, acc_q_q;

  logic          al [NS+1];
  logic [CW-1:0] cn [NS+1];
  logic [W-1:0]  ai [NS+1];
  logic [W-1:0]  aq [NS+1];
  logic [NS-1:0] en, done, ferr;
  lane_slot_t    slot [NS];

  assign al[0] = aligned_q;
  assign cn[0] = cnt_q;
  assign ai[0] = acc_i_q;
  assign aq[0] = acc_q_q;

  // slot 0 is the older falling-edge bit in double-rate mode
  assign slot[0] = ddr_i ? fall_i : live_i;
  assign en[0]   = 1'b1;

  generate
    for (genvar s = 1; s < NS; s++) begin : g_late
      assign slot[s] = live_i;
      assign en[s]   = ddr_i;
    end
    for (genvar s = 0; s < NS; s++) begin : g_step
      iq_slot_step #(.W(W), .CW(CW)) u_step (
        .en_i      (en[s]),
        .lsb_i     (lsb_i),
        .nbits_i   (nbits_i),
        .slot_i    (slot[s]),
        .aligned_i (al[s]),
        .cnt_i     (cn[s]),
        .acc_i_i   (ai[s]),
        .acc_q_i   (aq[s]),
        .aligned_o (al[s+1]),
        .cnt_o     (cn[s+1]),
        .acc_i_o   (ai[s+1]),
        .acc_q_o   (aq[s+1]),
        .done_o    (done[s]),
        .ferr_o    (ferr[s])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      cnt_q     <= '0;
      acc_i_q   <= '0;
      acc_q_q   <= '0;
    end else begin
      aligned_q <= al[NS];
      cnt_q     <= cn[NS];
      acc_i_q   <= ai[NS];
      acc_q_q   <= aq[NS];
    end
  end

  // pick the word from the stage that completed it
  always_comb begin
    word_i_o = ai[1];
    word_q_o = aq[1];
    for (int s = 1; s < NS; s++) begin
      if (done[s]) begin
        word_i_o = ai[s+1];
        word_q_o = aq[s+1];
      end
    end
  end

  assign done_o = |done;
  assign ferr_o = |ferr;

  AST_DONE_NEEDS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> aligned_q); // R2
  AST_ONE_WORD_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W)); // R3

endmodule

// File: rtl/iq_word_out.sv
module iq_word_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic         ferr_i,
  input  logic [W-1:0] word_i_i,
  input  logic [W-1:0] word_q_i,
  output logic         valid_o,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= done_i;
      err_o   <= err_o | ferr_i;
      if (done_i) begin
        i_o <= word_i_i;
        q_o <= word_q_i;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(i_o) && $stable(q_o))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
  AST_ERR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_i |=> err_o); // R9

endmodule

// File: rtl/iq_lane_deser.sv
module iq_lane_deser
  import iq_deser_pkg::*;
#(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              width16_i,
  input  logic              lsb_first_i,
  input  logic              ddr_i,
  input  logic              strobe_i,
  input  logic              i_lane_i,
  input  logic              q_lane_i,
  output logic              valid_o,
  output logic [LONG_W-1:0] i_word_o,
  output logic [LONG_W-1:0] q_word_o,
  output logic              frame_err_o
);

  localparam int unsigned CW = $clog2(LONG_W + 1);

  bit_order_e    order;
  cap_mode_e     mode;
  logic [CW-1:0] nbits;
  lane_slot_t    live, fall;
  logic          done, ferr;
  logic [LONG_W-1:0] wi, wq;

  assign order = bit_order_e'(lsb_first_i);
  assign mode  = cap_mode_e'(ddr_i);
  assign nbits = width16_i ? CW'(LONG_W) : CW'(SHORT_W);
  assign live  = '{stb: strobe_i, di: i_lane_i, dq: q_lane_i};

  iq_ddr_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (live),
    .fall_o (fall)
  );

  iq_deser_core #(.W(LONG_W), .CW(CW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ddr_i    (mode == CAP_DDR),
    .lsb_i    (order == ORD_LSB),
    .nbits_i  (nbits),
    .live_i   (live),
    .fall_i   (fall),
    .done_o   (done),
    .ferr_o   (ferr),
    .word_i_o (wi),
    .word_q_o (wq)
  );

  iq_word_out #(.W(LONG_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .ferr_i   (ferr),
    .word_i_i (wi),
    .word_q_i (wq),
    .valid_o  (valid_o),
    .i_o      (i_word_o),
    .q_o      (q_word_o),
    .err_o    (frame_err_o)
  );

endmodule

// File: tb/iq_lane_deser_test.sv
module iq_lane_deser_test;

  localparam int CLK_PERIOD = 8;
  localparam int DRV_OFS    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w16 = 1'b1, lsb = 1'b0, ddr = 1'b0;
  logic stb = 1'b0, il = 1'b0, ql = 1'b0;
  logic        valid;
  logic [15:0] iw, qw;
  logic        ferr;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0, mon_on = 0;
  string cur_tag = "R2";

  int          due_q[$];
  logic [15:0] ei_q[$], eq_q[$];
  string       tag_q[$];
  int          err_due = -1;
  logic [15:0] last_i = '0, last_q = '0;

  bit   m_active = 0;
  int   m_cnt = 0;
  logic m_bi[16], m_bq[16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iq_lane_deser uut (
    .clk_i(clk), .rst_ni(rst_n), .width16_i(w16), .lsb_first_i(lsb), .ddr_i(ddr),
    .strobe_i(stb), .i_lane_i(il), .q_lane_i(ql),
    .valid_o(valid), .i_word_o(iw), .q_word_o(qw), .frame_err_o(ferr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench model: collect bits in arrival order, place them by requirement
  task automatic model_slot(input logic s, input logic i, input logic q);
    int n;
    logic [15:0] wi, wq;
    n = w16 ? 16 : 12;
    if (s) begin
      if (m_active && m_cnt > 0 && err_due < 0) err_due = cyc + 1; // R9
      m_active = 1;
      m_cnt = 0;
    end
    if (s || (m_active && m_cnt > 0)) begin
      m_bi[m_cnt] = i;
      m_bq[m_cnt] = q;
      m_cnt++;
    end
    if (m_cnt == n) begin
      wi = '0; wq = '0;
      for (int k = 0; k < n; k++) begin
        wi[lsb ? k : n-1-k] = m_bi[k];
        wq[lsb ? k : n-1-k] = m_bq[k];
      end
      due_q.push_back(cyc + 1);
      ei_q.push_back(wi);
      eq_q.push_back(wq);
      tag_q.push_back(cur_tag);
      m_cnt = 0;
    end
  endtask

  task automatic drive(input logic s, input logic i, input logic q);
    if (ddr) @(clk);
    else     @(posedge clk);
    #DRV_OFS;
    stb = s; il = i; ql = q;
    model_slot(s, i, q);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic junk(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'($urandom), 1'($urandom));
  endtask

  task automatic set_cfg(input logic w, input logic l, input logic d);
    idle(3);
    w16 = w; lsb = l; ddr = d;
    idle(3);
  endtask

  task automatic send_word(input logic [15:0] wi, input logic [15:0] wq);
    int n;
    n = w16 ? 16 : 12;
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = lsb ? k : n-1-k;
      drive(k == 0, wi[idx], wq[idx]);
    end
  endtask

  task automatic send_partial(input int len);
    drive(1'b1, 1'($urandom), 1'($urandom));
    for (int k = 1; k < len; k++) drive(1'b0, 1'($urandom), 1'($urandom));
  endtask

  // monitor: outputs sampled on the falling edge, due cycle exact
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (valid) begin
          if (due_q.size() == 0 || due_q[0] != cyc) begin
            check(0, cur_tag, "unexpected or mistimed valid_o", 32'(cyc),
                  due_q.size() ? 32'(due_q[0]) : 32'hFFFF_FFFF);
            if (due_q.size() && due_q[0] < cyc) begin
              void'(due_q.pop_front()); void'(ei_q.pop_front());
              void'(eq_q.pop_front()); void'(tag_q.pop_front());
            end
          end else begin
            check(iw == ei_q[0], tag_q[0], "i_word_o (R6)", 32'(iw), 32'(ei_q[0]));
            check(qw == eq_q[0], tag_q[0], "q_word_o (R6)", 32'(qw), 32'(eq_q[0]));
            last_i = ei_q[0]; last_q = eq_q[0];
            void'(due_q.pop_front()); void'(ei_q.pop_front());
            void'(eq_q.pop_front()); void'(tag_q.pop_front());
          end
        end else begin
          if (due_q.size() && due_q[0] <= cyc) begin
            check(0, tag_q[0], "missing valid_o", 32'(cyc), 32'(due_q[0]));
            void'(due_q.pop_front()); void'(ei_q.pop_front());
            void'(eq_q.pop_front()); void'(tag_q.pop_front());
          end
          if (iw != last_i || qw != last_q)
            check(0, "R8", "words changed without valid_o", {iw, qw}, {last_i, last_q});
        end
        check(ferr == (err_due >= 0 && cyc >= err_due), "R9 R11", "frame_err_o",
              32'(ferr), 32'(err_due >= 0 && cyc >= err_due));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(valid == 0, "R1", "valid_o in reset", 32'(valid), 0);
    check(ferr == 0, "R1", "frame_err_o in reset", 32'(ferr), 0);
    @(posedge clk); #DRV_OFS; rst_n = 1'b1;
    @(negedge clk);
    check(valid == 0 && iw == 0 && qw == 0, "R1", "outputs after reset",
          {valid, iw[14:0], qw}, 0);
    check(ferr == 0, "R1", "frame_err_o after reset", 32'(ferr), 0);
    mon_on = 1;

    cur_tag = "R2"; junk(40);                            // R2: no strobe yet
    cur_tag = "R3"; send_word(16'hA5C3, 16'h1234);        // R3 R6
    cur_tag = "R10"; junk(20);                            // R10
    cur_tag = "R3"; send_word(16'h8001, 16'h7FFE); idle(2);
    set_cfg(1'b0, 1'b0, 1'b0);
    cur_tag = "R4"; send_word(16'h0ABC, 16'h0F0F); send_word(16'h0800, 16'h0001);
    set_cfg(1'b1, 1'b1, 1'b0);
    cur_tag = "R5"; send_word(16'h0001, 16'hC35A);
    set_cfg(1'b0, 1'b1, 1'b0);
    cur_tag = "R5"; send_word(16'h0123, 16'h0800);
    set_cfg(1'b1, 1'b0, 1'b1);
    cur_tag = "R7"; send_word(16'hDEAD, 16'hBEEF);        // strobe in one slot kind
    drive(1'b0, 1'b0, 1'b0);                              // shift phase by one slot
    cur_tag = "R7"; send_word(16'h1357, 16'h2468);        // strobe in the other kind
    cur_tag = "R10"; junk(9);
    set_cfg(1'b0, 1'b1, 1'b1);
    cur_tag = "R7"; send_word(16'h0FA5, 16'h0333);
    set_cfg(1'b1, 1'b0, 1'b0);
    cur_tag = "R9"; send_partial(5); send_word(16'h4C4C, 16'hB3B3);
    cur_tag = "R11"; idle(4); send_word(16'h00FF, 16'hFF00);

    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0) set_cfg(1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(7) == 0) begin
        cur_tag = "R9";
        send_partial(int'($urandom_range((w16 ? 15 : 11), 1)));
      end
      cur_tag = ddr ? "R7" : (w16 ? "R3" : "R4");
      send_word(w16 ? 16'($urandom) : {4'h0, 12'($urandom)},
                w16 ? 16'($urandom) : {4'h0, 12'($urandom)});
      if ($urandom_range(3) == 0) begin
        cur_tag = "R10";
        junk(int'($urandom_range(4)));
      end
    end
    idle(8);
    check(due_q.size() == 0, "R8", "words still outstanding", 32'(due_q.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule